// File: doc/BRIEF.md
# Stereo Soft Mute Ramp with Silence Detector

This block sits in a stereo PCM path ahead of the digital filtering stage. Each frame carries one left and one right 24-bit two's complement sample, marked by a single-cycle valid strobe. A mute request does not cut the audio abruptly. It steers a gain counter that moves by one step per frame between unity and silence. Each sample is multiplied by that gain, so muting and unmuting are both click-free fades. If the request changes while a fade is in progress, the fade turns around from its current level.

The block also watches the incoming samples, before any gain is applied, for a long run of digital silence. It raises a flag once both channels have been exactly zero for a long run of consecutive frames. It drops the flag on the first frame that carries any non-zero sample.

The stream edge has no back-pressure. The block takes every frame that is offered, one per cycle at most. Each scaled frame appears exactly one clock later with its own strobe, and downstream logic must take it in that cycle. `RAMP_STEPS` must be a power of two.

Top module: `soft_mute_zd`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `out_valid` and `zero_flag` are low and both outputs are zero. The gain restarts at unity (count `RAMP_STEPS` = 1024), so the first frame after reset passes unchanged.
- R2: `out_valid` is high in exactly those cycles that follow a cycle in which `in_valid` was high. The output latency is a fixed one clock.
- R3: Each output sample equals floor(sample × g / 1024), where g is the gain count held before that frame's own step. At g = 1024 the output equals the input exactly, and at g = 0 it is exactly zero.
- R4: On each valid frame with `mute_req` high, g drops by one and stops at 0. Starting from unity, the 1024th muted frame still carries gain 1/1024, and every muted frame after it is silent.
- R5: On each valid frame with `mute_req` low, g rises by one and stops at 1024. A full recovery from silence therefore takes 1024 frames.
- R6: If `mute_req` falls during a fade toward silence, g climbs back from its current value at one step per frame. After N muted frames from unity, N unmuted frames restore unity.
- R7: g does not change in cycles where `in_valid` is low, whatever `mute_req` does in those cycles.
- R8: `zero_flag` rises on the clock that accepts the 8192nd consecutive valid frame in which both input samples equal 000000. It then stays high while all-zero frames continue, and the run count saturates instead of wrapping.
- R9: A valid frame with a non-zero sample on either channel clears `zero_flag` on that clock and restarts the run count from zero.
- R10: Cycles with `in_valid` low neither extend nor break a zero run, whatever the sample inputs carry in those cycles.
- R11: Full-scale codes 7FFFFF and 800000 and small negative values are scaled with arithmetic (floor) rounding, with no overflow at any gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Frame strobe for the input samples |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| mute_req | input | 1 | Fade toward silence while high, toward unity while low |
| out_valid | output | 1 | Frame strobe for the scaled samples |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| zero_flag | output | 1 | High after a long run of all-zero input frames |

## Verification
The properties assume that every input is at a known level on each rising edge and that the reset is released away from a clock edge. They also assume that a gain step follows from `mute_req` as it is sampled on the same edge as the frame strobe. The stimulus changes all inputs only on falling edges and holds `in_valid` low during reset. Between frames it deliberately toggles `mute_req` and puts non-zero junk on the sample lines, so the rules that only strobed frames count are exercised within those assumptions rather than avoided.

// File: rtl/smz_pkg.sv
package smz_pkg;
  // Direction the gain counter takes on an accepted frame.
  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_DOWN = 2'd1,
    RAMP_UP   = 2'd2
  } ramp_dir_e;

  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/smz_gain_ramp.sv
module smz_gain_ramp #(
  parameter int unsigned RAMP_STEPS = 1024,
  parameter int unsigned GW         = $clog2(RAMP_STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          mute,
  output logic [GW-1:0] gain
);
  import smz_pkg::*;

  localparam logic [GW-1:0] G_MAX = GW'(RAMP_STEPS);

  ramp_dir_e dir;

  always_comb begin
    if (!step_en)                 dir = RAMP_HOLD;
    else if (mute && gain != '0)  dir = RAMP_DOWN;
    else if (!mute && gain != G_MAX) dir = RAMP_UP;
    else                          dir = RAMP_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain <= G_MAX;
    end else begin
      unique case (dir)
        RAMP_DOWN: gain <= gain - GW'(1);
        RAMP_UP:   gain <= gain + GW'(1);
        default:   gain <= gain;
      endcase
    end
  end
endmodule

// File: rtl/smz_gain_scale.sv
module smz_gain_scale #(
  parameter int unsigned SAMPLE_W   = 24,
  parameter int unsigned RAMP_STEPS = 1024,
  parameter int unsigned GW         = $clog2(RAMP_STEPS + 1)
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_valid,
  input  logic [smz_pkg::NUM_CH-1:0][SAMPLE_W-1:0] in_smp,
  input  logic [GW-1:0]                          gain,
  output logic                                   out_valid,
  output logic [smz_pkg::NUM_CH-1:0][SAMPLE_W-1:0] out_smp
);
  import smz_pkg::*;

  localparam int unsigned SHIFT = $clog2(RAMP_STEPS);
  localparam int unsigned PW    = SAMPLE_W + GW + 1;

  logic signed [PW-1:0] gain_ext;
  assign gain_ext = PW'($signed({1'b0, gain}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic signed [PW-1:0] smp_ext;
    logic signed [PW-1:0] prod;

    assign smp_ext = PW'($signed(in_smp[ch]));
    assign prod    = smp_ext * gain_ext;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        out_smp[ch] <= '0;
      else if (in_valid) out_smp[ch] <= SAMPLE_W'(prod >>> SHIFT);
    end
  end
endmodule

// File: rtl/smz_zero_watch.sv
module smz_zero_watch #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned ZERO_RUN = 8192
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   frame_en,
  input  logic [smz_pkg::NUM_CH-1:0][SAMPLE_W-1:0] in_smp,
  output logic                                   flag
);
  import smz_pkg::*;

  localparam int unsigned RW = $clog2(ZERO_RUN + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(ZERO_RUN);

  logic [NUM_CH-1:0] ch_zero;
  logic [RW-1:0]     run;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_zero
    assign ch_zero[ch] = (in_smp[ch] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0;
    end else if (frame_en) begin
      if (!(&ch_zero))        run <= '0;
      else if (run != RUN_MAX) run <= run + RW'(1);
    end
  end

  assign flag = (run == RUN_MAX);
endmodule

// File: rtl/soft_mute_zd.sv
module soft_mute_zd #(
  parameter int unsigned SAMPLE_W   = 24,
  parameter int unsigned RAMP_STEPS = 1024,
  parameter int unsigned ZERO_RUN   = 8192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic                mute_req,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right,
  output logic                zero_flag
);
  import smz_pkg::*;

  localparam int unsigned GW = $clog2(RAMP_STEPS + 1);

  logic [NUM_CH-1:0][SAMPLE_W-1:0] in_pair;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] out_pair;
  logic [GW-1:0]                   ramp_gain;

  assign in_pair[0] = in_left;
  assign in_pair[1] = in_right;
  assign out_left   = out_pair[0];
  assign out_right  = out_pair[1];

  smz_gain_ramp #(
    .RAMP_STEPS(RAMP_STEPS),
    .GW        (GW)
  ) u_ramp (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_en(in_valid),
    .mute   (mute_req),
    .gain   (ramp_gain)
  );

  smz_gain_scale #(
    .SAMPLE_W  (SAMPLE_W),
    .RAMP_STEPS(RAMP_STEPS),
    .GW        (GW)
  ) u_scale (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_smp   (in_pair),
    .gain     (ramp_gain),
    .out_valid(out_valid),
    .out_smp  (out_pair)
  );

  smz_zero_watch #(
    .SAMPLE_W(SAMPLE_W),
    .ZERO_RUN(ZERO_RUN)
  ) u_zero (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_en(in_valid),
    .in_smp  (in_pair),
    .flag    (zero_flag)
  );
endmodule

// File: rtl/smz_checker.sv
module smz_checker #(
  parameter int unsigned SAMPLE_W   = 24,
  parameter int unsigned RAMP_STEPS = 1024,
  parameter int unsigned GW         = $clog2(RAMP_STEPS + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [SAMPLE_W-1:0] in_left,
  input logic [SAMPLE_W-1:0] in_right,
  input logic                mute_req,
  input logic [GW-1:0]       ramp_gain,
  input logic                out_valid,
  input logic [SAMPLE_W-1:0] out_left,
  input logic [SAMPLE_W-1:0] out_right,
  input logic                zero_flag
);
  localparam logic [GW-1:0] G_MAX = GW'(RAMP_STEPS);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r2_valid_lag: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_idle_lag: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r3_silent_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ramp_gain == '0) |=> (out_left == '0 && out_right == '0));

  a_r3_unity_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ramp_gain == G_MAX) |=>
      (out_left == $past(in_left) && out_right == $past(in_right)));

  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mute_req && ramp_gain != '0) |=>
      ramp_gain == $past(ramp_gain) - GW'(1));

  a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mute_req && ramp_gain != G_MAX) |=>
      ramp_gain == $past(ramp_gain) + GW'(1));

  a_r5_gain_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_gain <= G_MAX);

  a_r7_hold_without_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(ramp_gain));

  a_r9_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_left != '0 || in_right != '0)) |=> !zero_flag);

  a_r8_flag_rises_on_zero_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(zero_flag)) |->
      $past(in_valid && in_left == '0 && in_right == '0));
endmodule

bind soft_mute_zd smz_checker #(
  .SAMPLE_W  (SAMPLE_W),
  .RAMP_STEPS(RAMP_STEPS),
  .GW        (GW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_left  (in_left),
  .in_right (in_right),
  .mute_req (mute_req),
  .ramp_gain(ramp_gain),
  .out_valid(out_valid),
  .out_left (out_left),
  .out_right(out_right),
  .zero_flag(zero_flag)
);

// File: tb/soft_mute_zd_test.sv
module soft_mute_zd_test;
  localparam int CLK_PERIOD = 10;
  localparam int SW   = 24;
  localparam int FULL = 1024;
  localparam int RUN  = 8192;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          mute_req = 1'b0;
  logic [SW-1:0] in_left = '0;
  logic [SW-1:0] in_right = '0;
  logic          out_valid;
  logic [SW-1:0] out_left;
  logic [SW-1:0] out_right;
  logic          zero_flag;

  soft_mute_zd uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_left  (in_left),
    .in_right (in_right),
    .mute_req (mute_req),
    .out_valid(out_valid),
    .out_left (out_left),
    .out_right(out_right),
    .zero_flag(zero_flag)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  int mdl_g  = FULL;

  logic [SW-1:0] q_l[$];
  logic [SW-1:0] q_r[$];
  string         q_tag[$];

  function automatic logic [SW-1:0] scale(logic [SW-1:0] x, int g);
    longint p;
    p = longint'($signed(x)) * longint'(g);
    return SW'(p >>> 10);
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Driver: one frame per call, expected result pushed to the scoreboard.
  task automatic send(logic [SW-1:0] l, logic [SW-1:0] r, logic m, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_left  = l;
    in_right = r;
    mute_req = m;
    q_l.push_back(scale(l, mdl_g));
    q_r.push_back(scale(r, mdl_g));
    q_tag.push_back(tag);
    if (m && mdl_g > 0) mdl_g--;
    else if (!m && mdl_g < FULL) mdl_g++;
  endtask

  // Idle cycles with junk on the sample lines and a chosen mute level (R7, R10).
  task automatic idle(int n, logic m);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_left  = 24'h0A5A5A + SW'(i);
      in_right = 24'hF00001;
      mute_req = m;
    end
  endtask

  task automatic check_flag(logic exp, string tag);
    @(negedge clk);
    in_valid = 1'b0;
    check(zero_flag === exp, tag, "zero_flag", longint'(zero_flag), longint'(exp));
  endtask

  // Monitor: compares each output frame against the scoreboard head (R2, R3).
  logic v_seen;
  always @(posedge clk) begin
    v_seen = in_valid;
    #1;
    if (rst_n) begin
      check(out_valid === v_seen, "R2", "out_valid", longint'(out_valid), longint'(v_seen));
      if (out_valid === 1'b1) begin
        if (q_l.size() == 0) begin
          check(1'b0, "R2", "unexpected frame", 1, 0);
        end else begin
          logic [SW-1:0] el, er;
          string t;
          el = q_l.pop_front();
          er = q_r.pop_front();
          t  = q_tag.pop_front();
          check(out_left === el, t, "out_left", longint'(out_left), longint'(el));
          check(out_right === er, t, "out_right", longint'(out_right), longint'(er));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
    check(zero_flag === 1'b0, "R1", "zero_flag in reset", longint'(zero_flag), 0);
    check(out_left === '0 && out_right === '0, "R1", "outputs in reset",
          longint'(out_left), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && zero_flag === 1'b0, "R1", "after release",
          longint'({out_valid, zero_flag}), 0);

    // R1/R3/R11: unity pass-through and extreme codes
    send(24'h123456, 24'hFEDCBA, 1'b0, "R1");
    send(24'h7FFFFF, 24'h800000, 1'b0, "R11");
    send(24'hFFFFFF, 24'h000001, 1'b0, "R3");

    // R4: full fade to silence, then stay silent
    for (int i = 0; i < FULL + 6; i++)
      send(24'h400000, 24'hC00000, 1'b1, "R4");
    send(24'h7FFFFF, 24'h800000, 1'b1, "R4");

    // R5: full fade back to unity, then stay there
    for (int i = 0; i < FULL + 4; i++)
      send(24'h7FFFFF, 24'h800000, 1'b0, "R5");
    send(24'h0ABCDE, 24'hF54321, 1'b0, "R5");

    // R6: reversal mid-fade, small negatives for floor rounding (R11)
    for (int i = 0; i < 300; i++)
      send(24'hFFFFFF, 24'h3FFFFF, 1'b1, "R6");
    for (int i = 0; i < 300; i++)
      send(24'hFFFFFD, 24'h800000, 1'b0, "R6");
    send(24'h55AA55, 24'hAA55AA, 1'b0, "R6");

    // R7: gaps with mute toggling must not move the gain
    for (int i = 0; i < 40; i++) begin
      send(24'h200000, 24'hE00000, 1'b1, "R7");
      idle(3, 1'b0);
      idle(2, 1'b1);
    end
    for (int i = 0; i < 60; i++) begin
      send(24'h200000, 24'hE00000, 1'b0, "R7");
      idle(2, 1'b1);
    end

    // R8: flag rises exactly on the 8192nd all-zero frame
    for (int i = 0; i < RUN - 1; i++) send('0, '0, 1'b0, "R8");
    check_flag(1'b0, "R8");
    send('0, '0, 1'b0, "R8");
    check_flag(1'b1, "R8");
    for (int i = 0; i < 20; i++) send('0, '0, 1'b0, "R8");
    check_flag(1'b1, "R8");

    // R10: idle cycles with junk keep the flag
    idle(7, 1'b0);
    check_flag(1'b1, "R10");

    // R9: a non-zero right sample clears at once
    send('0, 24'h000005, 1'b0, "R9");
    check_flag(1'b0, "R9");

    // R10: run interleaved with idle junk still counts only frames
    for (int i = 0; i < RUN - 1; i++) begin
      send('0, '0, 1'b0, "R10");
      if (i % 1024 == 0) idle(2, 1'b0);
    end
    check_flag(1'b0, "R10");
    send('0, '0, 1'b0, "R10");
    check_flag(1'b1, "R10");

    // R9: a non-zero left sample mid-run restarts the count
    send(24'h800000, '0, 1'b0, "R9");
    check_flag(1'b0, "R9");
    for (int i = 0; i < 4000; i++) send('0, '0, 1'b0, "R9");
    send(24'h000001, '0, 1'b0, "R9");
    for (int i = 0; i < RUN - 1; i++) send('0, '0, 1'b0, "R9");
    check_flag(1'b0, "R9");
    send('0, '0, 1'b0, "R9");
    check_flag(1'b1, "R9");

    // R1: reset mid-fade with the flag high, then unity again
    for (int i = 0; i < 200; i++) send('0, '0, 1'b1, "R4");
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(zero_flag === 1'b0, "R1", "zero_flag cleared by reset", longint'(zero_flag), 0);
    @(negedge clk);
    rst_n = 1'b1;
    mdl_g = FULL;
    send(24'h654321, 24'h9ABCDE, 1'b0, "R1");
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(q_l.size() == 0, "R2", "scoreboard drained", longint'(q_l.size()), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule